// File: doc/BRIEF.md
# Two-Stage Virtual-Channel Wormhole Router

This block is a wormhole router with several virtual channels (VCs) on each port and a pipeline that is two cycles deep. A flit that arrives on an input port is written into the FIFO of its input VC at the first clock edge. In the following cycle, one combined step does four things: it assigns an output VC to head flits, arbitrates for the crossbar, moves the flit across the crossbar, and registers it onto the output link. The flit is therefore on the output at the second clock edge. The route travels inside the head flit as a destination-port field that was computed one hop earlier, so the router has no route-computation stage.

Flow control is credit based in both directions. Every output VC keeps a credit counter that starts at the depth of a downstream buffer. A switch grant spends one credit, and a credit returned from downstream adds one. When a flit leaves an input FIFO, the router returns a credit upstream that names the input VC it came from. A packet holds its output VC from the head flit until the tail flit. Switch arbitration is separable: a round-robin arbiter on each input chooses among that input's VCs, and a round-robin arbiter on each output chooses among the inputs.

Top module: `vcr2_router`

## Requirements
- R1: After reset, out_valid and up_cr_valid are all low, every VC is idle, and every output VC holds DEPTH credits. An output VC therefore accepts exactly DEPTH flits before any credit comes back.
- R2: A flit driven on an input in cycle n leaves on its output in cycle n+2 when it meets no contention and has a credit available.
- R3: The flit layout is: bit FW-1 marks a head flit, bit FW-2 marks a tail flit, bits [DW+PW-1:DW] give the destination output port, and bits [DW-1:0] are the payload. The flit leaves unchanged. A head flit takes the lowest-numbered output VC at its destination that is idle and has a credit. Body and tail flits use the VC their head took.
- R4: Flits of one input VC leave in the order they arrived.
- R5: In the same cycle that a flit appears on an output, the router pulses up_cr_valid on the flit's input port, with up_cr_vc set to the flit's input VC. Each input VC gets back one credit per flit.
- R6: An output VC with zero credits sends nothing. Each credit returned on dn_cr_valid/dn_cr_vc lets one more flit leave, two cycles after the credit is driven.
- R7: Each output port sends at most one flit per cycle. Among the inputs that contend for it, priority starts at input 0 after reset and then moves to the input just after the last winner.
- R8: Each input port sends at most one flit per cycle. Its VCs alternate in round-robin order when both are ready.
- R9: A head flit makes its output VC busy until that packet's tail flit leaves. Meanwhile another head flit to the same port receives a different idle VC, or waits if none is idle.
- R10: Each input VC buffers up to DEPTH flits while it is blocked and loses none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Flit present, one bit per input port |
| in_vc | input | NPORT*VW | Input VC of the flit, per port |
| in_flit | input | NPORT*FW | Arriving flit, per port |
| up_cr_valid | output | NPORT | Credit returned upstream, per input port |
| up_cr_vc | output | NPORT*VW | Input VC that the returned credit belongs to |
| out_valid | output | NPORT | Flit leaving, per output port |
| out_vc | output | NPORT*VW | Output VC of the leaving flit |
| out_flit | output | NPORT*FW | Leaving flit |
| dn_cr_valid | input | NPORT | Credit arriving from downstream, per output port |
| dn_cr_vc | input | NPORT*VW | Output VC that the arriving credit belongs to |

## Verification
A single head-tail flit with no other traffic measures the two-cycle latency. A four-flit packet tests ordering within one VC and whether the packet keeps its output VC. Two packets sent at the same time to one port show whether the router assigns a second VC or makes the head wait, and a tail that arrives later shows whether the VC is released. Two inputs that stream flits back to back into one output separate round-robin from fixed priority, because the grants must alternate. A long packet that uses up its credits, followed by credits returned one at a time while a second VC on the same input competes, tests credit gating, when the router resumes, and rotation on the input side.

// File: rtl/vcr2_pkg.sv
package vcr2_pkg;

  typedef enum logic {VC_IDLE = 1'b0, VC_ACTIVE = 1'b1} vc_state_e;

  // credit count after one cycle of returns and spends
  function automatic int credit_next(int cur, logic give_back, logic spend);
    return cur + (give_back ? 1 : 0) - (spend ? 1 : 0);
  endfunction

  // slot visited at a given step after the last winner
  function automatic int rr_slot(int last, int step, int n);
    return (last + step) % n;
  endfunction

  // index of the lowest set bit, 0 when none
  function automatic int first_set(logic [31:0] v);
    int r;
    r = 0;
    for (int k = 31; k >= 0; k--) if (v[k]) r = k;
    return r;
  endfunction

endpackage

// File: rtl/vcr2_rr_arb.sv
module vcr2_rr_arb
  import vcr2_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] win;

  always_comb begin
    gnt = '0;
    win = last;
    for (int k = 1; k <= N; k++) begin
      if (req[rr_slot(int'(last), k, N)] && gnt == '0) begin
        gnt[rr_slot(int'(last), k, N)] = 1'b1;
        win = IW'(rr_slot(int'(last), k, N));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              last <= IW'(N - 1);
    else if (adv && |gnt)    last <= win;
  end

endmodule

// File: rtl/vcr2_vc_fifo.sv
module vcr2_vc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign rd_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/vcr2_router.sv
module vcr2_router
  import vcr2_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int FW   = 2 + PW + DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*VW-1:0] in_vc,
  input  logic [NPORT*FW-1:0] in_flit,
  output logic [NPORT-1:0]    up_cr_valid,
  output logic [NPORT*VW-1:0] up_cr_vc,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*VW-1:0] out_vc,
  output logic [NPORT*FW-1:0] out_flit,
  input  logic [NPORT-1:0]    dn_cr_valid,
  input  logic [NPORT*VW-1:0] dn_cr_vc
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int HB  = FW - 1;   // head marker
  localparam int TB  = FW - 2;   // tail marker

  // stage-1 storage
  logic [FW-1:0]              front [NPORT][NVC];
  logic [NPORT-1:0][NVC-1:0]  empty, wr, rd;

  // per-VC state
  vc_state_e     ivc_st   [NPORT][NVC];
  logic [VW-1:0] ivc_ovc  [NPORT][NVC];
  logic [PW-1:0] ivc_port [NPORT][NVC];
  vc_state_e     ovc_st   [NPORT][NVC];
  logic [PW-1:0] own_p    [NPORT][NVC];
  logic [VW-1:0] own_v    [NPORT][NVC];
  logic [CW-1:0] cred     [NPORT][NVC];

  // stage-2 events, named for the checks
  logic [NPORT-1:0]           free_any;
  logic [VW-1:0]              free_idx [NPORT];
  logic [NPORT-1:0][NVC-1:0]  elig;
  logic [PW-1:0]              tgt_p [NPORT][NVC];
  logic [VW-1:0]              tgt_v [NPORT][NVC];
  logic [NVC-1:0]             in_gnt [NPORT];
  logic [VW-1:0]              sel_v [NPORT];
  logic [NPORT-1:0]           req_out [NPORT];
  logic [NPORT-1:0]           out_gnt [NPORT];
  logic [NPORT-1:0]           in_hits [NPORT];
  logic [NPORT-1:0]           in_win;
  logic [NPORT-1:0]           xv;
  logic [PW-1:0]              xsrc [NPORT];
  logic [FW-1:0]              xflit [NPORT];
  logic [VW-1:0]              xvc [NPORT];
  logic [NPORT-1:0][NVC-1:0]  spend, refill;

  // stage 1: buffer write
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    for (genvar v = 0; v < NVC; v++) begin : g_vc
      assign wr[i][v] = in_valid[i] && (in_vc[i*VW +: VW] == VW'(v));
      vcr2_vc_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr[i][v]), .wr_data(in_flit[i*FW +: FW]),
        .rd_en(rd[i][v]), .rd_data(front[i][v]), .empty(empty[i][v])
      );
    end
    vcr2_rr_arb #(.N(NVC)) u_in_arb (
      .clk(clk), .rst_n(rst_n), .req(elig[i]), .adv(in_win[i]), .gnt(in_gnt[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    vcr2_rr_arb #(.N(NPORT)) u_out_arb (
      .clk(clk), .rst_n(rst_n), .req(req_out[o]), .adv(1'b1), .gnt(out_gnt[o])
    );
  end

  // stage 2: free VC lookup per output port
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      free_any[o] = 1'b0;
      free_idx[o] = '0;
      for (int v = NVC - 1; v >= 0; v--) begin
        if (ovc_st[o][v] == VC_IDLE && cred[o][v] != '0) begin
          free_any[o] = 1'b1;
          free_idx[o] = VW'(v);
        end
      end
    end
  end

  // stage 2: eligibility (VC allocation folded into the switch request)
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int v = 0; v < NVC; v++) begin
        elig[i][v]  = 1'b0;
        tgt_p[i][v] = front[i][v][DW +: PW];
        tgt_v[i][v] = '0;
        if (ivc_st[i][v] == VC_ACTIVE) begin
          tgt_p[i][v] = ivc_port[i][v];
          tgt_v[i][v] = ivc_ovc[i][v];
          elig[i][v]  = !empty[i][v] && (cred[ivc_port[i][v]][ivc_ovc[i][v]] != '0);
        end else if (!empty[i][v] && front[i][v][HB] &&
                     int'(front[i][v][DW +: PW]) < NPORT) begin
          tgt_v[i][v] = free_idx[front[i][v][DW +: PW]];
          elig[i][v]  = free_any[front[i][v][DW +: PW]];
        end
      end
    end
  end

  // stage 2: separable switch allocation and crossbar
  always_comb begin
    for (int i = 0; i < NPORT; i++) sel_v[i] = VW'(first_set(32'(in_gnt[i])));
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++) begin
        req_out[o][i] = (|in_gnt[i]) && (int'(tgt_p[i][sel_v[i]]) == o);
        in_hits[i][o] = out_gnt[o][i];
      end
    for (int i = 0; i < NPORT; i++) begin
      in_win[i] = |in_hits[i];
      for (int v = 0; v < NVC; v++) rd[i][v] = in_win[i] && in_gnt[i][v];
    end
    for (int o = 0; o < NPORT; o++) begin
      xv[o]    = |out_gnt[o];
      xsrc[o]  = PW'(first_set(32'(out_gnt[o])));
      xflit[o] = front[xsrc[o]][sel_v[xsrc[o]]];
      xvc[o]   = tgt_v[xsrc[o]][sel_v[xsrc[o]]];
      for (int v = 0; v < NVC; v++) begin
        spend[o][v]  = xv[o] && (xvc[o] == VW'(v));
        refill[o][v] = dn_cr_valid[o] && (dn_cr_vc[o*VW +: VW] == VW'(v));
      end
    end
  end

  // output link and upstream credit registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= '0;
      out_vc      <= '0;
      out_flit    <= '0;
      up_cr_valid <= '0;
      up_cr_vc    <= '0;
    end else begin
      out_valid   <= xv;
      up_cr_valid <= in_win;
      for (int o = 0; o < NPORT; o++) begin
        out_vc[o*VW +: VW]   <= xvc[o];
        out_flit[o*FW +: FW] <= xflit[o];
        up_cr_vc[o*VW +: VW] <= sel_v[o];
      end
    end
  end

  // VC state and credit counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++)
        for (int v = 0; v < NVC; v++) begin
          ivc_st[p][v]   <= VC_IDLE;
          ivc_ovc[p][v]  <= '0;
          ivc_port[p][v] <= '0;
          ovc_st[p][v]   <= VC_IDLE;
          own_p[p][v]    <= '0;
          own_v[p][v]    <= '0;
          cred[p][v]     <= CW'(DEPTH);
        end
    end else begin
      for (int o = 0; o < NPORT; o++)
        for (int v = 0; v < NVC; v++) begin
          cred[o][v] <= CW'(credit_next(int'(cred[o][v]), refill[o][v], spend[o][v]));
          if (spend[o][v]) begin
            if (xflit[o][TB]) ovc_st[o][v] <= VC_IDLE;
            else if (xflit[o][HB]) begin
              ovc_st[o][v] <= VC_ACTIVE;
              own_p[o][v]  <= xsrc[o];
              own_v[o][v]  <= sel_v[xsrc[o]];
            end
          end
        end
      for (int i = 0; i < NPORT; i++)
        for (int v = 0; v < NVC; v++)
          if (rd[i][v]) begin
            if (front[i][v][TB]) ivc_st[i][v] <= VC_IDLE;
            else if (front[i][v][HB]) begin
              ivc_st[i][v]   <= VC_ACTIVE;
              ivc_ovc[i][v]  <= tgt_v[i][v];
              ivc_port[i][v] <= tgt_p[i][v];
            end
          end
    end
  end

  // checks
  assert_credit_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(up_cr_valid));

  for (genvar o = 0; o < NPORT; o++) begin : g_chk_o
    assert_single_input_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_hits[o]));
    assert_head_takes_idle_vc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xv[o] && xflit[o][HB]) |-> ovc_st[o][xvc[o]] == VC_IDLE);
    assert_body_follows_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xv[o] && !xflit[o][HB]) |->
        (ovc_st[o][xvc[o]] == VC_ACTIVE && own_p[o][xvc[o]] == xsrc[o]
         && own_v[o][xvc[o]] == sel_v[xsrc[o]]));
    for (genvar v = 0; v < NVC; v++) begin : g_chk_v
      assert_credit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cred[o][v] <= CW'(DEPTH));
      assert_spend_needs_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spend[o][v] |-> cred[o][v] != '0);
    end
  end

endmodule

// File: tb/vcr2_router_tb.sv
module vcr2_router_tb;
  localparam int NP = 5;
  localparam int NV = 2;
  localparam int DP = 4;
  localparam int DW = 8;
  localparam int PW = 3;
  localparam int VW = 1;
  localparam int FW = 2 + PW + DW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*VW-1:0]  in_vc = '0;
  logic [NP*FW-1:0]  in_flit = '0;
  logic [NP-1:0]     up_cr_valid, out_valid;
  logic [NP*VW-1:0]  up_cr_vc, out_vc;
  logic [NP*FW-1:0]  out_flit;
  logic [NP-1:0]     dn_cr_valid;
  logic [NP*VW-1:0]  dn_cr_vc;
  logic [NP-1:0]     man_v = '0, auto_v = '0;
  logic [NP*VW-1:0]  man_vc = '0, auto_vc = '0;
  logic              auto_cr = 1'b1;

  assign dn_cr_valid = man_v | auto_v;
  assign dn_cr_vc    = (man_v != '0) ? man_vc : auto_vc;

  vcr2_router #(.NPORT(NP), .NVC(NV), .DEPTH(DP), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .up_cr_valid(up_cr_valid), .up_cr_vc(up_cr_vc), .out_valid(out_valid),
    .out_vc(out_vc), .out_flit(out_flit), .dn_cr_valid(dn_cr_valid), .dn_cr_vc(dn_cr_vc)
  );

  always #4 clk = ~clk;   // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int            lg_n [NP];
  int            lg_cyc [NP][64];
  logic [FW-1:0] lg_flit [NP][64];
  int            lg_vc [NP][64];
  int            ucr_n [NP];
  int            ucr_cyc [NP][64];
  int            ucr_vc [NP][64];

  // monitor: logs outputs and, when enabled, returns downstream credits
  always @(negedge clk) begin
    for (int o = 0; o < NP; o++) begin
      auto_v[o] = auto_cr && rst_n && out_valid[o];
      auto_vc[o*VW +: VW] = out_vc[o*VW +: VW];
      if (rst_n && out_valid[o] && lg_n[o] < 64) begin
        lg_cyc[o][lg_n[o]]  = cyc;
        lg_flit[o][lg_n[o]] = out_flit[o*FW +: FW];
        lg_vc[o][lg_n[o]]   = int'(out_vc[o*VW +: VW]);
        lg_n[o]++;
      end
      if (rst_n && up_cr_valid[o] && ucr_n[o] < 64) begin
        ucr_cyc[o][ucr_n[o]] = cyc;
        ucr_vc[o][ucr_n[o]]  = int'(up_cr_vc[o*VW +: VW]);
        ucr_n[o]++;
      end
    end
  end

  function automatic logic [FW-1:0] mk(logic h, logic t, int d, int pl);
    return {h, t, PW'(d), DW'(pl)};
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic put(int p, int vc, logic h, logic t, int d, int pl);
    in_valid[p] = 1'b1;
    in_vc[p*VW +: VW] = VW'(vc);
    in_flit[p*FW +: FW] = mk(h, t, d, pl);
  endtask

  task automatic give_credit(int p, int vc);
    man_v[p] = 1'b1;
    man_vc[p*VW +: VW] = VW'(vc);
  endtask

  task automatic step();
    @(negedge clk); #1;
    in_valid = '0;
    man_v = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0;
    man_v = '0;
    auto_cr = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    for (int o = 0; o < NP; o++) begin lg_n[o] = 0; ucr_n[o] = 0; end
    rst_n = 1'b1;
    idle(1);
  endtask

  function automatic int ucr_count(int p, int vc);
    int n;
    n = 0;
    for (int k = 0; k < ucr_n[p]; k++) if (ucr_vc[p][k] == vc) n++;
    return n;
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 up_cr_valid after reset", int'(up_cr_valid), 0);
  endtask

  task automatic t_latency();
    int c;
    do_reset();
    c = cyc;
    put(0, 0, 1'b1, 1'b1, 2, 8'hA5);
    step();
    idle(4);
    check("R2 one flit on port 2", lg_n[2], 1);
    check("R2 exit cycle", lg_cyc[2][0] - c, 2);
    check("R3 flit unchanged", int'(lg_flit[2][0]), int'(mk(1'b1, 1'b1, 2, 8'hA5)));
    check("R3 lowest output vc", lg_vc[2][0], 0);
    check("R2 no stray output", lg_n[0] + lg_n[1] + lg_n[3] + lg_n[4], 0);
    check("R5 one upstream credit", ucr_n[0], 1);
    check("R5 credit same cycle", ucr_cyc[0][0] - c, 2);
    check("R5 credit names vc", ucr_vc[0][0], 0);
  endtask

  task automatic t_packet();
    int c;
    do_reset();
    c = cyc;
    for (int k = 0; k < 4; k++) begin
      put(1, 1, k == 0, k == 3, 3, 8'h10 + k);
      step();
    end
    idle(5);
    check("R4 four flits", lg_n[3], 4);
    for (int k = 0; k < 4; k++) begin
      check("R4 order", int'(lg_flit[3][k]), int'(mk(k == 0, k == 3, 3, 8'h10 + k)));
      check("R2 back-to-back timing", lg_cyc[3][k] - c, 2 + k);
      check("R3 packet keeps vc", lg_vc[3][k], 0);
    end
    check("R5 credits for input vc1", ucr_count(1, 1), 4);
  endtask

  task automatic t_vc_hold();
    int d;
    do_reset();
    put(0, 0, 1'b1, 1'b0, 4, 8'h01);
    put(1, 0, 1'b1, 1'b0, 4, 8'h02);
    step();
    put(2, 0, 1'b1, 1'b1, 4, 8'h03);
    step();
    idle(5);
    check("R9 third head waits", lg_n[4], 2);
    check("R9 first head payload", int'(lg_flit[4][0][7:0]), 8'h01);
    check("R9 first head vc0", lg_vc[4][0], 0);
    check("R9 second head payload", int'(lg_flit[4][1][7:0]), 8'h02);
    check("R9 second head vc1", lg_vc[4][1], 1);
    d = cyc;
    put(0, 0, 1'b0, 1'b1, 4, 8'h04);
    step();
    idle(5);
    check("R9 tail and waiter out", lg_n[4], 4);
    check("R9 tail on vc0", int'(lg_flit[4][2]), int'(mk(1'b0, 1'b1, 4, 8'h04)));
    check("R9 tail cycle", lg_cyc[4][2] - d, 2);
    check("R9 waiter payload", int'(lg_flit[4][3][7:0]), 8'h03);
    check("R9 freed vc0 reused", lg_vc[4][3], 0);
    check("R9 waiter cycle", lg_cyc[4][3] - d, 3);
  endtask

  task automatic t_rr_output();
    int c;
    int exp_pl [4] = '{8'h00, 8'h10, 8'h01, 8'h11};
    do_reset();
    c = cyc;
    put(0, 0, 1'b1, 1'b1, 2, 8'h00);
    put(1, 0, 1'b1, 1'b1, 2, 8'h10);
    step();
    put(0, 0, 1'b1, 1'b1, 2, 8'h01);
    put(1, 0, 1'b1, 1'b1, 2, 8'h11);
    step();
    idle(6);
    check("R7 four flits", lg_n[2], 4);
    for (int k = 0; k < 4; k++) begin
      check("R7 alternating winner", int'(lg_flit[2][k][7:0]), exp_pl[k]);
      check("R7 one per cycle", lg_cyc[2][k] - c, 2 + k);
    end
  endtask

  task automatic t_credit();
    int k0, m;
    do_reset();
    auto_cr = 1'b0;
    for (int k = 0; k < 7; k++) begin
      put(0, 0, k == 0, k == 6, 1, 8'h20 + k);
      step();
    end
    idle(5);
    check("R1 DEPTH credits then stall", lg_n[1], DP);
    check("R6 last before stall", int'(lg_flit[1][3][7:0]), 8'h23);
    k0 = cyc;
    give_credit(1, 0);
    step();
    idle(4);
    check("R6 one credit one flit", lg_n[1], 5);
    check("R6 resume timing", lg_cyc[1][4] - k0, 2);
    check("R10 buffered flit intact", int'(lg_flit[1][4][7:0]), 8'h24);
    m = cyc;
    give_credit(1, 0);
    put(0, 1, 1'b1, 1'b0, 3, 8'h30);
    step();
    give_credit(1, 0);
    put(0, 1, 1'b0, 1'b1, 3, 8'h31);
    step();
    idle(6);
    check("R8 vc1 head first", lg_cyc[3][0] - m, 2);
    check("R8 vc0 body next", lg_cyc[1][5] - m, 3);
    check("R8 vc1 tail next", lg_cyc[3][1] - m, 4);
    check("R8 vc0 tail last", lg_cyc[1][6] - m, 5);
    check("R10 all seven delivered", lg_n[1], 7);
    check("R10 final tail", int'(lg_flit[1][6]), int'(mk(1'b0, 1'b1, 1, 8'h26)));
    check("R5 credits vc0", ucr_count(0, 0), 7);
    check("R5 credits vc1", ucr_count(0, 1), 2);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_packet();
    t_vc_hold();
    t_rr_output();
    t_credit();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule